// File: doc/BRIEF.md
# Multilevel Priority Interrupt Controller

This block sits beside a 16-bit CPU and decides which of its interrupt levels is presented next. The levels have a fixed priority order. At the top is an internal error level. Below it are `N_ASSIGN` assignable levels, 24 by default. At the bottom is a trace level. Each assignable level collects up to `N_LINES` request lines into a sticky status word. Software reads that word to find the requesting device, and the read clears the bits it returns.

The interrupt offer to the CPU is a valid/ready stream. The payload is the fixed vector address, the level position and the index of the most significant set bit in that level's status word. Ready is the CPU's instruction-boundary strobe `irq_take`. A transfer happens on a clock edge where both `irq_valid` and `irq_take` are high. There is no back-pressure in the other direction. While the offer waits for `irq_take`, it may change to a more urgent level, or it may be withdrawn when its level is masked.

A transferred level becomes busy. Busy levels stack up. Each pulse on `irq_release` retires the most urgent busy level, so nested service unwinds in order. Only levels more urgent than every busy level may be offered. Masking an assignable level hides it from the offer but keeps its request pending.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no level is busy or pending, `irq_valid` is low, `irq_vector` is 0, and `mask_rd` is 0.
- R2: Among levels that are pending, unmasked and not blocked, the offer goes to the most urgent one. Urgency falls in this order: internal, assignable 0, assignable 1, and so on up to the last assignable level, then trace.
- R3: `irq_vector` is 8 for the internal level, 9 for trace, and 11+n for assignable level n. `irq_level` is the position in the urgency order: 0 for internal, n+1 for assignable n, and N_ASSIGN+1 for trace.
- R4: A transfer marks the offered level busy. While any level is busy, only levels strictly more urgent than every busy level are offered.
- R5: A pulse on `irq_release` clears only the most urgent busy level. A release while nothing is busy changes nothing.
- R6: Setting mask bit n (1 = inhibit) withdraws assignable level n from the offer, and the level's request stays pending until the bit is cleared. The internal and trace levels cannot be masked.
- R7: While request line j of assignable level n is high, bit j of that level's status word is set, and the bit stays set after the line drops. A read with `rd_en` and `rd_sel`=n returns the word on `rd_data` one cycle later and clears the word. Lines still high set their bits again.
- R8: `irq_src` is the bit index of the most significant set bit in the offered assignable level's status word. It is 0 for the internal and trace levels.
- R9: While nothing is offered, `irq_valid` is low and `irq_vector` holds the last vector that was offered.
- R10: A pulse on `err_req` or `trace_req` leaves that level pending until the level is transferred.
- R11: A write with `mask_wr_en` replaces the whole mask, and `mask_rd` shows the current mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_req | input | 1 | Internal error request |
| trace_req | input | 1 | Trace request |
| line_req | input | N_ASSIGN*N_LINES | Request lines; line j of level n is bit n*N_LINES+j |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | N_ASSIGN | New mask, bit n inhibits assignable level n |
| mask_rd | output | N_ASSIGN | Current mask |
| rd_en | input | 1 | Status word read strobe |
| rd_sel | input | $clog2(N_ASSIGN) | Assignable level to read |
| rd_data | output | N_LINES | Returned status word, valid the cycle after the read |
| irq_take | input | 1 | Instruction boundary; ready for the offer |
| irq_release | input | 1 | Retire the most urgent busy level |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vector | output | VEC_W | Vector address of the offer |
| irq_level | output | $clog2(N_ASSIGN+2) | Urgency position of the offer |
| irq_src | output | $clog2(N_LINES) | Most significant set bit of the offered status word |

## Verification
The assertions check several properties on every cycle. An offered level is never masked, and it is never as urgent as or less urgent than a busy level. The vector stays inside the legal address set and does not move while nothing is offered. A busy level appears only after a transfer, and a release retires exactly one busy level. The directed scenarios cover what a single cycle cannot show. A masked request comes back after the mask is cleared. A release unblocks the right lower levels. A read-clear returns and then drops the latched bits. The leftmost source index follows the words actually latched.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Vector address map, in decimal.
  localparam int unsigned VEC_INTERNAL    = 8;
  localparam int unsigned VEC_TRACE       = 9;
  localparam int unsigned VEC_ASSIGN_BASE = 11;

  // Vector of a level at urgency position pos among n_lvl levels.
  function automatic int unsigned level_vector(int unsigned pos, int unsigned n_lvl);
    if (pos == 0) return VEC_INTERNAL;
    if (pos == n_lvl - 1) return VEC_TRACE;
    return VEC_ASSIGN_BASE + pos - 1;
  endfunction
endpackage

// File: rtl/pic_status_bank.sv
module pic_status_bank #(
  parameter int unsigned N_ASSIGN = 24,
  parameter int unsigned N_LINES  = 16,
  parameter int unsigned SEL_W    = $clog2(N_ASSIGN)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_ASSIGN*N_LINES-1:0]   line_req,
  input  logic                          rd_en,
  input  logic [SEL_W-1:0]              rd_sel,
  output logic [N_LINES-1:0]            rd_data,
  output logic [N_ASSIGN*N_LINES-1:0]   words,
  output logic [N_ASSIGN-1:0]           nonzero
);
  logic [N_LINES-1:0] rd_ret;

  always_comb begin
    rd_ret = '0;
    if (32'(rd_sel) < N_ASSIGN) rd_ret = words[32'(rd_sel)*N_LINES +: N_LINES];
  end

  for (genvar g = 0; g < N_ASSIGN; g++) begin : g_lvl
    logic [N_LINES-1:0] word_q;
    logic               hit;
    assign hit = rd_en && (rd_sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= (hit ? '0 : word_q) | line_req[g*N_LINES +: N_LINES];
    end
    assign words[g*N_LINES +: N_LINES] = word_q;
    assign nonzero[g] = |word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_ret;
  end
endmodule

// File: rtl/pic_busy_stack.sv
module pic_busy_stack #(
  parameter int unsigned N_LVL = 26,
  parameter int unsigned LVL_W = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_en,
  input  logic [LVL_W-1:0] grant_idx,
  input  logic             release_i,
  output logic [N_LVL-1:0] busy
);
  logic [N_LVL-1:0] busy_q;
  logic [N_LVL-1:0] one;
  logic [N_LVL-1:0] rel_mask;
  logic [N_LVL-1:0] grant_mask;
  logic             top_valid;
  logic [LVL_W-1:0] top_idx;

  assign one = {{(N_LVL-1){1'b0}}, 1'b1};

  // The most urgent busy level is the lowest set index.
  always_comb begin
    top_valid = 1'b0;
    top_idx   = '0;
    for (int i = N_LVL - 1; i >= 0; i--) begin
      if (busy_q[i]) begin
        top_valid = 1'b1;
        top_idx   = LVL_W'(i);
      end
    end
  end

  assign rel_mask   = (release_i && top_valid) ? (one << top_idx) : '0;
  assign grant_mask = grant_en ? (one << grant_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~rel_mask) | grant_mask;
  end

  assign busy = busy_q;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned N_LVL = 26,
  parameter int unsigned LVL_W = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] pend,
  input  logic [N_LVL-1:0] inhibit,
  input  logic [N_LVL-1:0] busy,
  output logic             cand_valid,
  output logic [LVL_W-1:0] cand_idx
);
  logic [N_LVL-1:0] open_lvl;

  // A level is open when no level at its urgency or above is busy.
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = 0; i < N_LVL; i++) begin
      blocked     = blocked | busy[i];
      open_lvl[i] = !blocked;
    end
  end

  always_comb begin
    cand_valid = 1'b0;
    cand_idx   = '0;
    for (int i = N_LVL - 1; i >= 0; i--) begin
      if (pend[i] && !inhibit[i] && open_lvl[i]) begin
        cand_valid = 1'b1;
        cand_idx   = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_msb_find.sv
module pic_msb_find #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  word,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (word[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_ASSIGN = 24,
  parameter int unsigned N_LINES  = 16,
  parameter int unsigned VEC_W    = 16,
  localparam int unsigned N_LVL   = N_ASSIGN + 2,
  localparam int unsigned LVL_W   = $clog2(N_LVL),
  localparam int unsigned SEL_W   = $clog2(N_ASSIGN),
  localparam int unsigned SRC_W   = $clog2(N_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        err_req,
  input  logic                        trace_req,
  input  logic [N_ASSIGN*N_LINES-1:0] line_req,
  input  logic                        mask_wr_en,
  input  logic [N_ASSIGN-1:0]         mask_wr_data,
  output logic [N_ASSIGN-1:0]         mask_rd,
  input  logic                        rd_en,
  input  logic [SEL_W-1:0]            rd_sel,
  output logic [N_LINES-1:0]          rd_data,
  input  logic                        irq_take,
  input  logic                        irq_release,
  output logic                        irq_valid,
  output logic [VEC_W-1:0]            irq_vector,
  output logic [LVL_W-1:0]            irq_level,
  output logic [SRC_W-1:0]            irq_src
);
  localparam logic [LVL_W-1:0] TRACE_POS = LVL_W'(N_LVL - 1);

  logic [N_ASSIGN-1:0]         mask_q;
  logic                        err_pend_q;
  logic                        trace_pend_q;
  logic [VEC_W-1:0]            vec_q;
  logic [N_ASSIGN*N_LINES-1:0] words;
  logic [N_ASSIGN-1:0]         nonzero;
  logic [N_LVL-1:0]            pend;
  logic [N_LVL-1:0]            inhibit;
  logic [N_LVL-1:0]            busy_w;
  logic                        cand_valid;
  logic [LVL_W-1:0]            cand_idx;
  logic                        cand_assign;
  logic [SEL_W-1:0]            cand_sel;
  logic [N_LINES-1:0]          cand_word;
  logic                        src_found;
  logic [SRC_W-1:0]            src_idx;
  logic [VEC_W-1:0]            cand_vec;
  logic                        xfer;

  pic_status_bank #(.N_ASSIGN(N_ASSIGN), .N_LINES(N_LINES), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .line_req(line_req), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .words(words), .nonzero(nonzero)
  );

  assign pend    = {trace_pend_q, nonzero, err_pend_q};
  assign inhibit = {1'b0, mask_q, 1'b0};

  pic_arbiter #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_arb (
    .pend(pend), .inhibit(inhibit), .busy(busy_w),
    .cand_valid(cand_valid), .cand_idx(cand_idx)
  );

  assign xfer = cand_valid && irq_take;

  pic_busy_stack #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .grant_en(xfer), .grant_idx(cand_idx),
    .release_i(irq_release), .busy(busy_w)
  );

  assign cand_assign = (cand_idx != '0) && (cand_idx != TRACE_POS);
  assign cand_sel    = cand_assign ? SEL_W'(cand_idx - LVL_W'(1)) : '0;
  assign cand_word   = cand_assign ? words[32'(cand_sel)*N_LINES +: N_LINES] : '0;

  pic_msb_find #(.W(N_LINES), .IW(SRC_W)) u_msb (
    .word(cand_word), .found(src_found), .idx(src_idx)
  );

  assign cand_vec = VEC_W'(level_vector(32'(cand_idx), N_LVL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q       <= '0;
      err_pend_q   <= 1'b0;
      trace_pend_q <= 1'b0;
      vec_q        <= '0;
    end else begin
      if (mask_wr_en) mask_q <= mask_wr_data;
      err_pend_q   <= (err_pend_q && !(xfer && cand_idx == '0)) || err_req;
      trace_pend_q <= (trace_pend_q && !(xfer && cand_idx == TRACE_POS)) || trace_req;
      if (cand_valid) vec_q <= cand_vec;
    end
  end

  assign mask_rd    = mask_q;
  assign irq_valid  = cand_valid;
  assign irq_vector = cand_valid ? cand_vec : vec_q;
  assign irq_level  = cand_idx;
  assign irq_src    = src_found ? src_idx : '0;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned N_ASSIGN = 24,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned N_LVL    = N_ASSIGN + 2,
  parameter int unsigned LVL_W    = $clog2(N_LVL)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_valid,
  input logic                irq_take,
  input logic                irq_release,
  input logic [LVL_W-1:0]    irq_level,
  input logic [VEC_W-1:0]    irq_vector,
  input logic [N_LVL-1:0]    busy,
  input logic [N_ASSIGN-1:0] mask
);
  localparam int unsigned VEC_TOP = 11 + N_ASSIGN - 1;

  assert_take_marks_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_take) |=> busy[$past(irq_level)]);

  assert_offer_above_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((busy << (N_LVL - 1 - 32'(irq_level))) == '0));

  assert_no_busy_without_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && irq_take) |=> ($countones(busy) <= $past($countones(busy))));

  assert_release_retires_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_release && busy != '0 && !(irq_valid && irq_take)) |=>
      ($countones(busy) == $past($countones(busy)) - 1));

  assert_masked_not_offered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level != '0 && 32'(irq_level) != N_LVL - 1) |-> !mask[irq_level - LVL_W'(1)]);

  assert_vector_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (32'(irq_vector) >= 8 && 32'(irq_vector) != 10 && 32'(irq_vector) <= VEC_TOP));

  assert_vector_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> $stable(irq_vector));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .N_ASSIGN(N_ASSIGN), .VEC_W(VEC_W), .N_LVL(N_LVL), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_take(irq_take),
  .irq_release(irq_release), .irq_level(irq_level), .irq_vector(irq_vector),
  .busy(busy_w), .mask(mask_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 24;
  localparam int NL = 16;
  localparam int WATCHDOG = 5000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           err_req = 1'b0;
  logic           trace_req = 1'b0;
  logic [NA*NL-1:0] line_req = '0;
  logic           mask_wr_en = 1'b0;
  logic [NA-1:0]  mask_wr_data = '0;
  logic [NA-1:0]  mask_rd;
  logic           rd_en = 1'b0;
  logic [4:0]     rd_sel = '0;
  logic [NL-1:0]  rd_data;
  logic           irq_take = 1'b0;
  logic           irq_release = 1'b0;
  logic           irq_valid;
  logic [15:0]    irq_vector;
  logic [4:0]     irq_level;
  logic [3:0]     irq_src;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .err_req(err_req), .trace_req(trace_req),
    .line_req(line_req), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .mask_rd(mask_rd), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_take(irq_take), .irq_release(irq_release), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_level(irq_level), .irq_src(irq_src)
  );

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_line(int lvl, int ln);
    line_req[lvl*NL + ln] = 1'b1;
    step();
    line_req[lvl*NL + ln] = 1'b0;
  endtask

  task automatic take();
    irq_take = 1'b1; step(); irq_take = 1'b0;
  endtask

  task automatic release_one();
    irq_release = 1'b1; step(); irq_release = 1'b0;
  endtask

  task automatic read_word(int lvl);
    rd_en = 1'b1; rd_sel = 5'(lvl); step(); rd_en = 1'b0;
  endtask

  task automatic write_mask(logic [NA-1:0] m);
    mask_wr_en = 1'b1; mask_wr_data = m; step(); mask_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "valid", int'(irq_valid), 0);
    check("R1", "vector", int'(irq_vector), 0);
    check("R1", "mask", int'(mask_rd), 0);
  endtask

  task automatic t_single_and_source();
    pulse_line(5, 3);
    check("R3", "valid lvl5", int'(irq_valid), 1);
    check("R3", "vector lvl5", int'(irq_vector), 16);
    check("R3", "level lvl5", int'(irq_level), 6);
    check("R8", "src lvl5", int'(irq_src), 3);
    pulse_line(5, 9);
    pulse_line(5, 1);
    check("R8", "leftmost src", int'(irq_src), 9);
  endtask

  task automatic t_priority();
    pulse_line(2, 7);
    trace_req = 1'b1; step(); trace_req = 1'b0;
    check("R2", "vector lvl2 wins", int'(irq_vector), 13);
    check("R2", "level lvl2 wins", int'(irq_level), 3);
  endtask

  task automatic t_nesting();
    take();
    check("R4", "lower blocked", int'(irq_valid), 0);
    check("R9", "vector held", int'(irq_vector), 13);
    err_req = 1'b1; step(); err_req = 1'b0;
    check("R10", "err offered", int'(irq_valid), 1);
    check("R3", "err vector", int'(irq_vector), 8);
    check("R8", "err src", int'(irq_src), 0);
    take();
    check("R10", "err cleared", int'(irq_valid), 0);
    release_one();
    check("R5", "only internal retired", int'(irq_valid), 0);
    read_word(2);
    check("R7", "read lvl2", int'(rd_data), 16'h0080);
    read_word(2);
    check("R7", "read clears", int'(rd_data), 0);
    release_one();
    check("R5", "lvl5 unblocked", int'(irq_vector), 16);
  endtask

  task automatic t_mask();
    write_mask(24'h000020);
    check("R6", "masked -> trace", int'(irq_vector), 9);
    check("R6", "trace level", int'(irq_level), 25);
    check("R11", "mask readback", int'(mask_rd), 32'h20);
    write_mask('0);
    check("R6", "kept pending", int'(irq_vector), 16);
  endtask

  task automatic t_held_line();
    line_req[5*NL + 12] = 1'b1;
    step();
    read_word(5);
    check("R7", "read lvl5", int'(rd_data), 16'h120A);
    read_word(5);
    check("R7", "held line resets", int'(rd_data), 16'h1000);
    line_req[5*NL + 12] = 1'b0;
    read_word(5);
    check("R7", "last held bit", int'(rd_data), 16'h1000);
    check("R2", "trace left", int'(irq_vector), 9);
    take();
    release_one();
    check("R10", "trace cleared", int'(irq_valid), 0);
    check("R9", "trace vector held", int'(irq_vector), 9);
  endtask

  task automatic t_edge_level();
    release_one();
    check("R5", "empty release", int'(irq_valid), 0);
    pulse_line(23, 15);
    check("R3", "top vector", int'(irq_vector), 34);
    check("R3", "top level", int'(irq_level), 24);
    check("R8", "top src", int'(irq_src), 15);
    take();
    check("R4", "self blocked", int'(irq_valid), 0);
    release_one();
    check("R5", "re-offered", int'(irq_vector), 34);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single_and_source();
    t_priority();
    t_nesting();
    t_mask();
    t_held_line();
    t_edge_level();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule